// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the word address for each beat of a four-word burst in a synchronous memory. A base address is captured on the rising clock edge whenever either of two independent address strobes is high: one driven by a processor, one by a memory controller. On each later edge where no strobe is high and the advance input is high, the block steps a two-bit beat counter. The two low bits of the output address are then derived from the captured low bits and the beat count.

The derivation follows one of two orderings, chosen by a mode input at the moment of capture:
- **Sequential:** the low bits count upward and wrap modulo four.
- **Interleaved:** the low bits are the captured bits XORed with the beat count.

The upper address bits pass through unchanged for the whole burst. A strobe that arrives in the middle of a burst discards the old sequence and starts again from the new address.

All inputs are sampled at the positive clock edge. The address and beat position appear from registers in the cycle after the edge that caused them.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `addr_out` = 0, `beat_pos` = 0 and `beat_last` = 0.
- R2: A high `strb_cpu` or `strb_ctl` at an edge captures `addr_in`. In the next cycle, `addr_out` equals that `addr_in` exactly and `beat_pos` = 0.
- R3: A strobe has priority over `adv` at the same edge. A strobe in the middle of a burst restarts the sequence at beat 0 from the newly captured address.
- R4: At an edge with no strobe and `adv` high, `beat_pos` increases by one modulo 4. `beat_last` is high exactly when `beat_pos` = 3.
- R5: With sequential ordering (`ilv_mode` = 0 at capture), `addr_out[1:0]` = (captured low bits + `beat_pos`) mod 4. For example, start 1 gives 1,2,3,0.
- R6: With interleaved ordering (`ilv_mode` = 1 at capture), `addr_out[1:0]` = captured low bits XOR `beat_pos`. For example, start 1 gives 1,0,3,2.
- R7: `ilv_mode` is used only at a capturing edge. Changing it during a burst does not alter the ordering of that burst.
- R8: At an edge with no strobe and `adv` low, `addr_out`, `beat_pos` and `beat_last` keep their values.
- R9: The upper address bits (`addr_out[ADDR_W-1:2]`) change only at a capturing edge. In particular, a wrap of the low bits never carries into them.
- R10: After four advances, the address returns to the captured start address and `beat_pos` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External address captured on a strobe |
| strb_cpu | input | 1 | Processor-side address strobe, active high |
| strb_ctl | input | 1 | Controller-side address strobe, active high |
| adv | input | 1 | Advance to the next beat, active high |
| ilv_mode | input | 1 | Ordering select at capture: 0 sequential, 1 interleaved |
| addr_out | output | ADDR_W | Current burst word address |
| beat_pos | output | 2 | Beat index within the burst, 0 to 3 |
| beat_last | output | 1 | High on the fourth beat (`beat_pos` = 3) |

## Verification
The hardest case to reach from the ports combines three conditions: the low bits wrap while the upper bits are all ones, the ordering input flips mid-burst, and a restart strobe coincides with an advance. None of these appears in a plain load-then-advance run. The stimulus first loads `0x1FFFF` and `0x1FFFE` so that a sequential wrap would visibly carry if the upper bits were not isolated. It then toggles `ilv_mode` between advances of an already captured burst. Finally, it raises each strobe, and then both strobes together, in the same cycle as `adv` partway through a burst, and checks that the sequence starts again at beat 0.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Ordering of the low address bits across a burst
    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    // Per-edge action decoded from the strobes and the advance input
    typedef struct packed {
        logic load;
        logic step;
        logic idle;
    } burst_cmd_t;

    // Either strobe captures; advance only acts without a strobe
    function automatic burst_cmd_t decode_cmd(input logic s_cpu,
                                              input logic s_ctl,
                                              input logic advance);
        burst_cmd_t c;
        c.load = s_cpu | s_ctl;
        c.step = ~c.load & advance;
        c.idle = ~c.load & ~advance;
        return c;
    endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2,
    localparam int HI_W  = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_t        cmd,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ilv_mode,
    output logic [HI_W-1:0]   base_hi,
    output logic [BEAT_W-1:0] base_lo,
    output order_e            order_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi <= '0;
            base_lo <= '0;
            order_q <= ORD_SEQ;
        end else if (cmd.load) begin
            base_hi <= addr_in[ADDR_W-1:BEAT_W];
            base_lo <= addr_in[BEAT_W-1:0];
            order_q <= order_e'(ilv_mode);
        end
    end

    // Upper bits stay fixed unless a capture occurs
    p_base_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cmd.load |=> $stable(base_hi));

    // Ordering is frozen within a burst
    p_order_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !cmd.load |=> $stable(order_q));

endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_t        cmd,
    output logic [BEAT_W-1:0] beat_q,
    output logic              last
);

    always_ff @(posedge clk) begin
        if (rst || cmd.load) beat_q <= '0;
        else if (cmd.step)   beat_q <= beat_q + 1'b1;
    end

    assign last = &beat_q;

    p_beat_step_r4: assert property (@(posedge clk) disable iff (rst)
        cmd.step |=> beat_q == $past(beat_q) + 1'b1);

    p_beat_idle_r8: assert property (@(posedge clk) disable iff (rst)
        cmd.idle |=> $stable(beat_q));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] base_lo,
    input  logic [BEAT_W-1:0] beat,
    input  order_e            order,
    output logic [BEAT_W-1:0] low_out
);

    logic [BEAT_W-1:0] seq_lo;
    logic [BEAT_W-1:0] ilv_lo;

    // Sequential ordering: wrap-around add, no carry out of the field
    assign seq_lo = base_lo + beat;

    // Interleaved ordering: bitwise flip by the beat index
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_lo[b] = base_lo[b] ^ beat[b];
    end

    assign low_out = (order == ORD_ILV) ? ilv_lo : seq_lo;

    // At beat 0 both orderings present the captured bits (R2)
    always_comb begin
        if (beat == '0) a_beat0_start_r2: assert (low_out == base_lo);
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17,
    localparam int BEAT_W = 2,
    localparam int HI_W   = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strb_cpu,
    input  logic              strb_ctl,
    input  logic              adv,
    input  logic              ilv_mode,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BEAT_W-1:0] beat_pos,
    output logic              beat_last
);

    burst_cmd_t        cmd;
    logic [HI_W-1:0]   base_hi;
    logic [BEAT_W-1:0] base_lo;
    logic [BEAT_W-1:0] low_cur;
    order_e            order_q;

    assign cmd = decode_cmd(strb_cpu, strb_ctl, adv);

    burst_base_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .addr_in  (addr_in),
        .ilv_mode (ilv_mode),
        .base_hi  (base_hi),
        .base_lo  (base_lo),
        .order_q  (order_q)
    );

    burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .beat_q (beat_pos),
        .last   (beat_last)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .base_lo (base_lo),
        .beat    (beat_pos),
        .order   (order_q),
        .low_out (low_cur)
    );

    assign addr_out = {base_hi, low_cur};

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (strb_cpu || strb_ctl) |=> (addr_out == $past(addr_in)) && (beat_pos == '0));

    p_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (strb_cpu || strb_ctl) && adv |=> beat_pos == '0);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !strb_cpu && !strb_ctl && !adv |=> $stable(addr_out) && $stable(beat_last));

    p_upper_r9: assert property (@(posedge clk) disable iff (rst)
        !strb_cpu && !strb_ctl |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    p_last_r4: assert property (@(posedge clk) disable iff (rst)
        adv && !strb_cpu && !strb_ctl && beat_last |=> beat_pos == '0);

endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          strb_cpu = 1'b0, strb_ctl = 1'b0, adv = 1'b0, ilv_mode = 1'b0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_pos;
    logic          beat_last;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .addr_in(addr_in), .strb_cpu(strb_cpu),
        .strb_ctl(strb_ctl), .adv(adv), .ilv_mode(ilv_mode),
        .addr_out(addr_out), .beat_pos(beat_pos), .beat_last(beat_last)
    );

    // Reference state, kept from the requirements alone
    logic [AW-1:0] m_base = '0;
    int            m_beat = 0;
    bit            m_ilv  = 0;

    logic [AW-1:0] q_addr[$];
    int            q_pos[$];
    string         q_tag[$];

    task automatic step(input bit r, input bit sc, input bit sk, input bit a,
                        input bit m, input logic [AW-1:0] ad, input string tag);
        logic [AW-1:0] e;
        int lo;
        @(negedge clk);
        rst = r; strb_cpu = sc; strb_ctl = sk; adv = a; ilv_mode = m; addr_in = ad;
        if (r) begin
            m_base = '0; m_beat = 0; m_ilv = 0;
        end else if (sc || sk) begin
            m_base = ad; m_beat = 0; m_ilv = m;
        end else if (a) begin
            m_beat = (m_beat + 1) % 4;
        end
        lo = m_ilv ? (int'(m_base[1:0]) ^ m_beat) : ((int'(m_base[1:0]) + m_beat) % 4);
        e = {m_base[AW-1:2], 2'(lo)};
        q_addr.push_back(e);
        q_pos.push_back(m_beat);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare after each edge
    always @(posedge clk) begin
        #2;
        if (q_addr.size() > 0) begin
            logic [AW-1:0] ea;
            int ep;
            string t;
            ea = q_addr.pop_front(); ep = q_pos.pop_front(); t = q_tag.pop_front();
            checks++;
            if (addr_out !== ea || int'(beat_pos) != ep || beat_last !== (ep == 3)) begin
                errors++;
                $display("FAIL %s: addr=%h pos=%0d last=%b expected addr=%h pos=%0d last=%b",
                         t, addr_out, beat_pos, beat_last, ea, ep, (ep == 3));
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1,0,0,0,0,'h0, "R1");
        step(1,1,0,1,1,'h1ABCD, "R1");
        // R2 + R5 sequential from start 1 via processor strobe
        step(0,1,0,0,0,'h12345, "R2");
        step(0,0,0,1,0,'h0, "R5");
        step(0,0,0,1,0,'h0, "R5");
        step(0,0,0,1,0,'h0, "R4");
        step(0,0,0,1,0,'h0, "R10");
        // R8 hold
        step(0,0,0,0,0,'h0, "R8");
        step(0,0,0,1,0,'h0, "R5");
        step(0,0,0,0,1,'h3FFF, "R8");
        // R6 interleaved start 1 via controller strobe
        step(0,0,1,0,1,'h00A81, "R6");
        step(0,0,0,1,1,'h0, "R6");
        step(0,0,0,1,1,'h0, "R6");
        step(0,0,0,1,1,'h0, "R6");
        step(0,0,0,1,1,'h0, "R10");
        // R6 interleaved start 2 and 3
        step(0,1,0,0,1,'h0F0F2, "R6");
        for (int i = 0; i < 4; i++) step(0,0,0,1,1,'h0, "R6");
        step(0,0,1,0,1,'h0F0F3, "R6");
        for (int i = 0; i < 4; i++) step(0,0,0,1,1,'h0, "R6");
        // R9 upper bits all ones, sequential wrap must not carry
        step(0,1,0,0,0,'h1FFFF, "R9");
        for (int i = 0; i < 4; i++) step(0,0,0,1,0,'h0, "R9");
        step(0,0,1,0,0,'h1FFFE, "R9");
        for (int i = 0; i < 4; i++) step(0,0,0,1,0,'h0, "R9");
        // R7 mode change mid-burst ignored
        step(0,1,0,0,0,'h00402, "R7");
        step(0,0,0,1,1,'h0, "R7");
        step(0,0,0,1,1,'h0, "R7");
        step(0,0,0,0,1,'h0, "R7");
        step(0,0,0,1,0,'h0, "R7");
        step(0,0,1,0,1,'h00402, "R7");
        step(0,0,0,1,0,'h0, "R7");
        step(0,0,0,1,0,'h0, "R7");
        // R3 restart mid-burst with strobe and advance together
        step(0,0,0,1,0,'h0, "R3");
        step(0,1,0,1,1,'h15555, "R3");
        step(0,0,0,1,1,'h0, "R3");
        step(0,0,1,1,0,'h0AAAA, "R3");
        step(0,0,0,1,0,'h0, "R3");
        step(0,1,1,1,1,'h13337, "R3");
        step(0,0,0,1,0,'h0, "R3");
        // R1 reset in the middle of a burst
        step(1,0,0,1,0,'h0, "R1");
        step(0,0,0,1,0,'h0, "R4");
        // drain
        step(0,0,0,0,0,'h0, "R8");
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule